// File: doc/BRIEF.md
# Size-Configurable Bank Chip-Select Decoder

This block sits between a memory controller's address path and the pins of an external memory bus. Each cycle it takes an internal byte address, one-hot size bits for the slow (boot flash) region and the fast (SRAM) region, a region select and a read/write flag. From these it registers four active-low bank chip enables, a slow-region enable, and a pair of active-low half-bank enables. The pair of address bits that picks one of the four banks depends on the configured memory size, so a larger part pushes the bank select toward the top of the address.

In the fast region the low and high half-bank enables are driven from a single address bit that also moves with the size setting. In the slow region the low half-bank pin is used instead to steer an external data-buffer direction, and the high pin is held inactive. Size settings that are not exactly one-hot deselect every bank, and so does a cycle with no access. Bus timing and the data path are outside this block.

Top module: `mem_cs_decoder`

## Requirements
- R1: The two-bit bank index drives exactly one chip enable low: index 0 gives bank_ce_n=4'b1110, 1 gives 4'b1101, 2 gives 4'b1011 and 3 gives 4'b0111.
- R2: In the slow region (slow_sel=1) the bank index is address bits 18:17 when flash_size=3'b001 (2 MB), bits 19:18 when flash_size=3'b010 (4 MB) and bits 20:19 when flash_size=3'b100 (8 MB).
- R3: In the fast region (slow_sel=0) the bank index is address bits 17:16 for sram_size=4'b0001 (1 MB), 18:17 for 4'b0010 (2 MB), 19:18 for 4'b0100 (4 MB) and 20:19 for 4'b1000 (8 MB).
- R4: In the fast region the half-bank bit is address bit 15, 16, 17 or 18 for the four sram_size settings of R3 in the same order; a half bit of 0 gives half_lo_n=0, half_hi_n=1, and a half bit of 1 gives half_lo_n=1, half_hi_n=0.
- R5: slow_en_n is 0 for a decoded slow-region access and 1 for a fast-region access.
- R6: In a decoded slow-region access half_lo_n carries the buffer direction, 0 for a write (wr_en=1) and 1 for a read (wr_en=0), and half_hi_n is 1.
- R7: When the size bits of the selected region are zero or have more than one bit set, all chip enables, slow_en_n, half_lo_n and half_hi_n are 1; the size bits of the region not selected have no effect on any output.
- R8: When acc_valid is 0 all outputs are 1.
- R9: Outputs are registered: they show the inputs sampled at the previous rising clock edge, and they are all 1 while reset is held and during the two cycles after its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | An access is in progress this cycle |
| slow_sel | input | 1 | 1 = slow (boot flash) region, 0 = fast (SRAM) region |
| wr_en | input | 1 | 1 = write, 0 = read |
| flash_size | input | 3 | One-hot slow-region size: bit0 2 MB, bit1 4 MB, bit2 8 MB |
| sram_size | input | 4 | One-hot fast-region size: bit0 1 MB, bit1 2 MB, bit2 4 MB, bit3 8 MB |
| acc_addr | input | 6 | Internal byte address bits 20:15 |
| bank_ce_n | output | 4 | Active-low bank chip enables |
| half_lo_n | output | 1 | Low half-bank enable (fast) or buffer direction (slow) |
| half_hi_n | output | 1 | High half-bank enable, active low |
| slow_en_n | output | 1 | Active-low slow-region enable |

## Verification
The hardest situation to reach is one where the region that is not selected carries a legal size while the selected region carries a zero or multi-hot pattern, or the reverse, because a decoder that reads the wrong group still looks right for most inputs. The stimulus sweeps every pattern of both size groups against every value of the decoded address span, both directions and both access states, and always loads the unselected group with a different, often legal, pattern. Expected pins come from a shift-and-mask model of the bit positions in the requirements.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int CS_BANKS     = 4;
  localparam int CS_FLASH_N   = 3;
  localparam int CS_SRAM_N    = 4;
  localparam int CS_ADDR_LSB  = 15;
  localparam int CS_ADDR_MSB  = 20;
  localparam int CS_FLASH_LSB = 17;
  localparam int CS_SRAM_LSB  = 16;

  typedef struct packed {
    logic [CS_BANKS-1:0] ce_n;
    logic                lo_n;
    logic                hi_n;
    logic                slow_n;
  } mcs_pins_t;

  localparam mcs_pins_t MCS_IDLE = '{ce_n: '1, lo_n: 1'b1, hi_n: 1'b1, slow_n: 1'b1};
endpackage

// File: rtl/mcs_onehot_idx.sv
// Checks a size group for exactly one set bit and encodes its position.
module mcs_onehot_idx #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  bits,
  output logic          valid,
  output logic [IW-1:0] idx
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (bits[k]) begin
        cnt = cnt + CW'(1);
        idx = IW'(k);
      end
    end
    valid = (cnt == CW'(1));
  end
endmodule

// File: rtl/mcs_field_pick.sv
// Picks an FW-bit address field whose lowest bit sits at BASE+idx.
module mcs_field_pick #(
  parameter int N    = 4,
  parameter int FW   = 2,
  parameter int BASE = 16,
  localparam int IW  = (N > 1) ? $clog2(N) : 1,
  localparam int TOP = BASE + N + FW - 2
) (
  input  logic [TOP:BASE] fld,
  input  logic [IW-1:0]   idx,
  output logic [FW-1:0]   val
);
  always_comb begin
    val = '0;
    for (int k = 0; k < N; k++) begin
      if (idx == IW'(k)) val = fld[BASE+k +: FW];
    end
  end
endmodule

// File: rtl/mcs_bank_enable.sv
// Turns a bank index into active-low one-cold enables.
module mcs_bank_enable #(
  parameter int NB = 4,
  localparam int SW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          en,
  input  logic [SW-1:0] sel,
  output logic [NB-1:0] ce_n
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign ce_n[b] = !(en && (sel == SW'(b)));
  end
endmodule

// File: rtl/mem_cs_decoder.sv
module mem_cs_decoder
  import mcs_pkg::*;
#(
  parameter int NB        = CS_BANKS,
  parameter int FLASH_N   = CS_FLASH_N,
  parameter int SRAM_N    = CS_SRAM_N,
  parameter int ADDR_LSB  = CS_ADDR_LSB,
  parameter int ADDR_MSB  = CS_ADDR_MSB,
  parameter int FLASH_LSB = CS_FLASH_LSB,
  parameter int SRAM_LSB  = CS_SRAM_LSB
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  input  logic                   slow_sel,
  input  logic                   wr_en,
  input  logic [FLASH_N-1:0]     flash_size,
  input  logic [SRAM_N-1:0]      sram_size,
  input  logic [ADDR_MSB:ADDR_LSB] acc_addr,
  output logic [NB-1:0]          bank_ce_n,
  output logic                   half_lo_n,
  output logic                   half_hi_n,
  output logic                   slow_en_n
);
  localparam int SW      = $clog2(NB);
  localparam int FIW     = (FLASH_N > 1) ? $clog2(FLASH_N) : 1;
  localparam int SIW     = (SRAM_N > 1) ? $clog2(SRAM_N) : 1;
  localparam int HALF_LSB = SRAM_LSB - 1;
  localparam int F_TOP   = FLASH_LSB + FLASH_N + SW - 2;
  localparam int S_TOP   = SRAM_LSB + SRAM_N + SW - 2;
  localparam int H_TOP   = HALF_LSB + SRAM_N - 1;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Size group decode.
  logic           flash_ok, sram_ok;
  logic [FIW-1:0] flash_idx;
  logic [SIW-1:0] sram_idx;

  mcs_onehot_idx #(.N(FLASH_N)) u_flash_idx (
    .bits(flash_size), .valid(flash_ok), .idx(flash_idx));
  mcs_onehot_idx #(.N(SRAM_N)) u_sram_idx (
    .bits(sram_size), .valid(sram_ok), .idx(sram_idx));

  // Address field selection.
  logic [SW-1:0] flash_pair, sram_pair, bank_sel;
  logic          half_bit;

  mcs_field_pick #(.N(FLASH_N), .FW(SW), .BASE(FLASH_LSB)) u_flash_pair (
    .fld(acc_addr[F_TOP:FLASH_LSB]), .idx(flash_idx), .val(flash_pair));
  mcs_field_pick #(.N(SRAM_N), .FW(SW), .BASE(SRAM_LSB)) u_sram_pair (
    .fld(acc_addr[S_TOP:SRAM_LSB]), .idx(sram_idx), .val(sram_pair));
  mcs_field_pick #(.N(SRAM_N), .FW(1), .BASE(HALF_LSB)) u_half (
    .fld(acc_addr[H_TOP:HALF_LSB]), .idx(sram_idx), .val(half_bit));

  // Next-state.
  logic          go;
  logic [NB-1:0] ce_nxt;
  logic          lo_nxt, hi_nxt, slow_nxt;

  assign go       = acc_valid && (slow_sel ? flash_ok : sram_ok);
  assign bank_sel = slow_sel ? flash_pair : sram_pair;

  mcs_bank_enable #(.NB(NB)) u_bank (
    .en(go), .sel(bank_sel), .ce_n(ce_nxt));

  always_comb begin
    slow_nxt = 1'b1;
    lo_nxt   = 1'b1;
    hi_nxt   = 1'b1;
    if (go) begin
      if (slow_sel) begin
        slow_nxt = 1'b0;
        lo_nxt   = !wr_en;
      end else begin
        lo_nxt   = half_bit;
        hi_nxt   = !half_bit;
      end
    end
  end

  // Output register.
  logic pins_en;
  assign pins_en = 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bank_ce_n <= '1;
      half_lo_n <= 1'b1;
      half_hi_n <= 1'b1;
      slow_en_n <= 1'b1;
    end else if (pins_en) begin
      bank_ce_n <= ce_nxt;
      half_lo_n <= lo_nxt;
      half_hi_n <= hi_nxt;
      slow_en_n <= slow_nxt;
    end
  end
endmodule

// File: rtl/mem_cs_decoder_chk.sv
module mem_cs_decoder_chk #(
  parameter int NB      = 4,
  parameter int FLASH_N = 3,
  parameter int SRAM_N  = 4
) (
  input logic               clk,
  input logic               rst_ok,
  input logic               acc_valid,
  input logic               slow_sel,
  input logic               wr_en,
  input logic [FLASH_N-1:0] flash_size,
  input logic [SRAM_N-1:0]  sram_size,
  input logic [NB-1:0]      bank_ce_n,
  input logic               half_lo_n,
  input logic               half_hi_n,
  input logic               slow_en_n
);
  AST_CE_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(~bank_ce_n)); // R1
  AST_SLOW_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_valid && slow_sel && ($countones(flash_size) == 1)
    |=> ($countones(~bank_ce_n) == 1) && !slow_en_n); // R2
  AST_FAST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_valid && !slow_sel && ($countones(sram_size) == 1)
    |=> ($countones(~bank_ce_n) == 1) && slow_en_n); // R3
  AST_HALF_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_valid && !slow_sel && ($countones(sram_size) == 1)
    |=> (half_lo_n != half_hi_n)); // R4
  AST_SLOW_DIRECTION: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_valid && slow_sel && ($countones(flash_size) == 1)
    |=> half_hi_n && (half_lo_n == !$past(wr_en))); // R6
  AST_BAD_SIZE_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_valid && (slow_sel ? ($countones(flash_size) != 1) : ($countones(sram_size) != 1))
    |=> (&bank_ce_n) && slow_en_n && half_lo_n && half_hi_n); // R7
  AST_NO_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    !acc_valid |=> (&bank_ce_n) && slow_en_n && half_lo_n && half_hi_n); // R8
endmodule

bind mem_cs_decoder mem_cs_decoder_chk #(.NB(NB), .FLASH_N(FLASH_N), .SRAM_N(SRAM_N)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .acc_valid(acc_valid), .slow_sel(slow_sel),
  .wr_en(wr_en), .flash_size(flash_size), .sram_size(sram_size),
  .bank_ce_n(bank_ce_n), .half_lo_n(half_lo_n), .half_hi_n(half_hi_n),
  .slow_en_n(slow_en_n));

// File: tb/mem_cs_decoder_tb.sv
module mem_cs_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, slow_sel, wr_en;
  logic [2:0]  flash_size;
  logic [3:0]  sram_size;
  logic [20:15] acc_addr;
  logic [3:0]  bank_ce_n;
  logic        half_lo_n, half_hi_n, slow_en_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mem_cs_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .slow_sel(slow_sel),
    .wr_en(wr_en), .flash_size(flash_size), .sram_size(sram_size),
    .acc_addr(acc_addr), .bank_ce_n(bank_ce_n), .half_lo_n(half_lo_n),
    .half_hi_n(half_hi_n), .slow_en_n(slow_en_n));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired: got cycles=%0d expected finish", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int pos1(input int v, input int n);
    int p = -1;
    int c = 0;
    for (int k = 0; k < n; k++) if ((v >> k) & 1) begin c++; p = k; end
    return (c == 1) ? p : -1;
  endfunction

  // Packed as {ce_n[3:0], lo_n, hi_n, slow_n}; addr a holds bits 20:15.
  function automatic logic [6:0] model(input bit v, input bit s, input int fsz,
                                       input int ssz, input int a, input bit w);
    int p, pair;
    if (!v) return 7'h7f;
    if (s) begin
      p = pos1(fsz, 3);
      if (p < 0) return 7'h7f;
      pair = (a >> (2 + p)) & 3;
      return {4'(~(1 << pair)), !w, 1'b1, 1'b0};
    end
    p = pos1(ssz, 4);
    if (p < 0) return 7'h7f;
    pair = (a >> (1 + p)) & 3;
    return {4'(~(1 << pair)), 1'((a >> p) & 1), !1'((a >> p) & 1), 1'b1};
  endfunction

  function automatic string tag(input bit v, input bit s, input int fsz, input int ssz);
    if (!v) return "R8";
    if (s) return (pos1(fsz, 3) < 0) ? "R7" : "R2/R5/R6";
    return (pos1(ssz, 4) < 0) ? "R7" : "R3/R4/R5";
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] got;
    got = {bank_ce_n, half_lo_n, half_hi_n, slow_en_n};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic drive(input bit v, input bit s, input int fsz, input int ssz,
                       input int a, input bit w);
    acc_valid = v; slow_sel = s; wr_en = w;
    flash_size = 3'(fsz); sram_size = 4'(ssz); acc_addr = 6'(a);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1, 1, 4, 0, 6'h30, 0);
    repeat (3) @(negedge clk);
    check("R9 reset", 7'h7f);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 sync release", 7'h7f);
    repeat (3) @(negedge clk);

    // R1: 8 MB flash, bank index on bits 20:19 (a[5:4]).
    for (int b = 0; b < 4; b++) begin
      drive(1, 1, 4, 0, b << 4, 0);
      @(negedge clk);
      case (b)
        0: check("R1 index0", {4'b1110, 3'b110});
        1: check("R1 index1", {4'b1101, 3'b110});
        2: check("R1 index2", {4'b1011, 3'b110});
        default: check("R1 index3", {4'b0111, 3'b110});
      endcase
    end

    // R9: change inputs; before the next edge the outputs still hold.
    drive(0, 0, 0, 0, 0, 0);
    #1 check("R9 holds until edge", {4'b0111, 3'b110});
    @(negedge clk);
    check("R9 after edge", 7'h7f);

    // Sweep: unselected group always carries a different pattern (R7).
    for (int v = 0; v < 2; v++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 16; c++)
          for (int a = 0; a < 64; a++)
            for (int w = 0; w < 2; w++) begin
              int fsz = s ? (c & 7) : ((c & 7) ^ 5);
              int ssz = s ? ((c + 3) & 15) : c;
              drive(v[0], s[0], fsz, ssz, a, w[0]);
              @(negedge clk);
              check(tag(v[0], s[0], fsz, ssz), model(v[0], s[0], fsz, ssz, a, w[0]));
            end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule